// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects single-cycle event pulses from many sub-blocks into one 32-bit sticky status word. A host reaches it through a one-cycle read/write strobe. Reading the status word returns the pending events and clears them in the same access. A mask word chooses which pending bits may raise the single interrupt output.

One bit position, the mirror bit (bit 23), does not follow these rules. It shows the pending level of a secondary management block. The host clears it by reading that block's own status register, and a read of this block does not clear it. The global mask cannot hide it, so it has to be masked where it starts. Every other bit is stored here and is cleared by the read.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word reads 0 when mgmt_irq_i is low, the mask word reads 0xFF7FFFFF, and irq_o is low.
- R2: A 1 on evt_i[b] for b other than 23 sets status bit b on the next clock edge. The bit stays set until a status read clears it.
- R3: A status read (req_i=1, we_i=0, addr_i=0) puts the current status on rdata_o in the same cycle. It clears every stored bit except bit 23 at that clock edge.
- R4: An event that arrives in the same cycle as a clearing status read is still set after the read.
- R5: Status bit 23 always equals mgmt_irq_i. A status read does not clear it, and evt_i[23] has no effect.
- R6: A mask write (req_i=1, we_i=1, addr_i=1) stores wdata_i at the clock edge, except bit 23, which always reads 0. A mask read (addr_i=1) returns the mask.
- R7: A mask bit of 1 suppresses its status bit and 0 enables it. irq_o is the OR of status AND NOT mask, and bit 23 is never masked.
- R8: Writes to the status address (addr_i=0) change neither the status nor the mask.
- R9: A mask read does not change the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per status bit |
| mgmt_irq_i | input | 1 | Pending level from the management block, mirrored into bit 23 |
| req_i | input | 1 | Single-cycle access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = status word, 1 = mask word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read strobe, otherwise 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench first sets status bits with pulses while the read port is idle. It reads twice to show that the bits stick and then clear. It then fires a pulse in the same cycle as a clearing read, which separates a design that lets a clear override a set from one that keeps the event. The management level is raised and read repeatedly, with all other bits masked, to show that bit 23 survives reads and ignores the mask. Status writes and mask reads are mixed with pending events to show that neither access disturbs the stored bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_W      = 32;
  localparam int unsigned MIRROR_BIT = 23;
  localparam logic [IRQ_W-1:0] MASK_RST = 32'hFF7F_FFFF;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W      = 32,
  parameter int unsigned MIRROR = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         mgmt_irq_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] status_o
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << MIRROR);

  logic [W-1:0] sticky_q, sticky_d;

  // set wins over clear so a colliding event is kept
  always_comb sticky_d = (rd_clr_i ? '0 : sticky_q) | (evt_i & KEEP);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= sticky_d;

  always_comb begin
    status_o = sticky_q;
    status_o[MIRROR] = mgmt_irq_i;
  end

  assert_clear_on_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && ((evt_i & KEEP) == '0)) |=> (sticky_q == '0));

  // covers R4 as well: set survives a same-cycle clear
  assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & KEEP) != '0) |=> ((sticky_q & $past(evt_i & KEEP)) == $past(evt_i & KEEP)));

  assert_sticky_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned   W      = 32,
  parameter int unsigned   MIRROR = 23,
  parameter logic [W-1:0]  RST    = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << MIRROR);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   mask_q <= RST & KEEP;
    else if (wr_i) mask_q <= wdata_i & KEEP;

  assign mask_o = mask_q;

  assert_mask_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W      = 32,
  parameter int unsigned MIRROR = 23
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] enabled;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == MIRROR) begin : g_unmasked
      assign enabled[b] = status_i[b];
    end else begin : g_masked
      assign enabled[b] = status_i[b] & ~mask_i[b];
    end
  end

  assign irq_o = |enabled;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] evt_i,
  input  logic             mgmt_irq_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] status, mask;
  logic rd_status, wr_mask, rd_mask;

  assign rd_status = req_i && !we_i && (addr_i == ADDR_STATUS);
  assign rd_mask   = req_i && !we_i && (addr_i == ADDR_MASK);
  assign wr_mask   = req_i &&  we_i && (addr_i == ADDR_MASK);

  irq_status_bank #(.W(IRQ_W), .MIRROR(MIRROR_BIT)) u_bank (
    .clk_i, .rst_ni, .evt_i, .mgmt_irq_i,
    .rd_clr_i (rd_status),
    .status_o (status)
  );

  irq_mask_reg #(.W(IRQ_W), .MIRROR(MIRROR_BIT), .RST(MASK_RST)) u_mask (
    .clk_i, .rst_ni,
    .wr_i    (wr_mask),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  irq_combine #(.W(IRQ_W), .MIRROR(MIRROR_BIT)) u_comb (
    .status_i (status),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_status)    rdata_o = status;
    else if (rd_mask) rdata_o = mask;
  end

  assert_mirror_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_irq_i |-> irq_o);

  assert_mirror_readback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status |-> (rdata_o[MIRROR_BIT] == mgmt_irq_i));

  assert_irq_needs_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mgmt_irq_i || ((status & ~mask) != '0)));
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic [31:0] evt = '0, wdata = '0, rdata;
  logic        mgmt = 0, req = 0, we = 0, addr = 0, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mgmt_irq_i(mgmt),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic wr(input logic a, input logic [31:0] v);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = v;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt = v;
    @(posedge clk); #1 evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(1'b1, d); check("R1 mask reset", d, 32'hFF7FFFFF);
    rd(1'b0, d); check("R1 status reset", d, 32'd0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    pulse(32'h0000_0005);
    repeat (3) @(posedge clk);
    #1 check("R7 masked bits give no irq", {31'd0, irq}, 32'd0);
    rd(1'b0, d); check("R2 sticky bits", d, 32'h0000_0005);
    rd(1'b0, d); check("R3 cleared by read", d, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); check("R6 mask bit23 reads 0", d, 32'hFF7F_FFFF);
    wr(1'b1, 32'hFFFF_FFFE);
    rd(1'b1, d); check("R6 mask readback", d, 32'hFF7F_FFFE);
    pulse(32'h0000_0002);
    check("R7 masked event no irq", {31'd0, irq}, 32'd0);
    pulse(32'h0000_0001);
    check("R7 unmasked event irq", {31'd0, irq}, 32'd1);
    rd(1'b0, d); check("R3 read returns both", d, 32'h0000_0003);
    check("R3 irq drops after read", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pulse(32'h0000_0040);
    @(negedge clk); req = 1; we = 0; addr = 1'b0; evt = 32'h0000_0010;
    #1 d = rdata;
    @(posedge clk); #1 req = 0; evt = '0;
    check("R3 read value before clear", d, 32'h0000_0040);
    rd(1'b0, d); check("R4 colliding event kept", d, 32'h0000_0010);
  endtask

  task automatic t_mirror;
    logic [31:0] d;
    wr(1'b1, 32'hFFFF_FFFF);
    @(negedge clk); mgmt = 1;
    #1 check("R5 mirror bypasses mask", {31'd0, irq}, 32'd1);
    rd(1'b0, d); check("R5 mirror in status", d, 32'h0080_0000);
    rd(1'b0, d); check("R5 mirror not cleared by read", d, 32'h0080_0000);
    @(negedge clk); mgmt = 0;
    #1 check("R5 mirror follows source", {31'd0, irq}, 32'd0);
    pulse(32'h0080_0000);
    rd(1'b0, d); check("R5 evt bit23 ignored", d, 32'd0);
    wr(1'b1, 32'hFF7F_FFFF);
  endtask

  task automatic t_status_write;
    logic [31:0] d;
    pulse(32'h0000_0100);
    wr(1'b0, 32'h0000_0000);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b1, d); check("R8 status write leaves mask", d, 32'hFF7F_FFFF);
    rd(1'b0, d); check("R8 status write ignored", d, 32'h0000_0100);
  endtask

  task automatic t_mask_read;
    logic [31:0] d;
    pulse(32'h0000_0008);
    rd(1'b1, d);
    rd(1'b1, d);
    rd(1'b0, d); check("R9 mask read keeps status", d, 32'h0000_0008);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_sticky();
    t_mask();
    t_collision();
    t_mirror();
    t_status_write();
    t_mask_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule